// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a free-running time count for hardware timestamping. On every clock cycle in which it is enabled, it adds a small programmable step to the count. A frequency trim is applied by replacing that step with a second, separately programmed step once in every N+1 counting cycles. No fractional accumulator is used. The count can be told to fold back by a programmable period, which turns it into a modulo timer (a period of 2^31 gives the usual 31-bit time base). When it folds, the block can raise a one-cycle wrap event for downstream compare channels.

Software controls the block through a small register bus. It can write the count directly, zero the count with a restart command, and take a stable snapshot of the count with a capture command. The snapshot is read back through the time register. The live count and the wrap event are driven straight out to neighbouring logic.

Top module: `ptc_timer`

## Requirements
- R1: After synchronous reset every register holds zero, the count is zero, the wrap event is low and the read data is zero.
- R2: While control bit 0 is set, the count grows each cycle by the normal step held in bits [6:0] of the step register (byte offset 0x14). While control bit 0 is clear, the count holds its value.
- R3: When the trim register (offset 0x10) holds a non-zero value P, one counting cycle in every P+1 adds the trim step from bits [14:8] of the step register instead of the normal step. A value of zero turns trimming off. Writing the trim register restarts the tally of counting cycles.
- R4: When control bits 5 and 4 are both set and the period register (offset 0x0C) is non-zero, any step that would bring the count to or past the period leaves count+step−period in its place. With either bit clear, no folding takes place.
- R5: A step that folds the count drives the wrap event high for exactly the following cycle, but only when control bit 7 is set. The wrap event is never high otherwise.
- R6: A control write (offset 0x00) with bit 9 set zeroes the count at that clock edge. This takes priority over counting.
- R7: A write to the time register (offset 0x04) loads the count with the written data at that clock edge.
- R8: A control write with bit 11 set latches the count held just before that edge. Reads of offset 0x04 return the latched value until the next capture. Bits 9 and 11 read back as zero.
- R9: Read data is registered and reflects the address presented one cycle earlier. Control reads return bits 0, 4, 5 and 7. The step register reads back both fields in place. Unmapped and unaligned addresses read as zero.
- R10: A register write takes effect from the cycle after the write. The step taken at the write edge uses the settings that held before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| time_now | output | CNT_W | Live count value |
| wrap_evt | output | 1 | One-cycle pulse after a folding step |

## Verification
The bench builds the block with its defaults: a 32-bit count and data bus and an 8-bit byte address. At these widths a fold at the full 2^31 period is reachable within a few cycles, because the bench loads the count just below the period through the time register. Short periods such as 100 make repeated folds with uneven steps occur many times in one run. Small trim values (P=3) make the one-in-four substitution visible in any four-cycle window of the count.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  localparam int INC_W = 7;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_TIME = 'h04;
  localparam int OFS_WPER = 'h0C;
  localparam int OFS_CPER = 'h10;
  localparam int OFS_STEP = 'h14;

  localparam int CB_RUN     = 0;
  localparam int CB_WRAP_LO = 4;
  localparam int CB_WRAP_HI = 5;
  localparam int CB_EVT     = 7;
  localparam int CB_RESTART = 9;
  localparam int CB_CAPTURE = 11;

  localparam int SB_NORM_LSB = 0;
  localparam int SB_TRIM_LSB = 8;

  typedef struct packed {
    logic       run;
    logic [1:0] wrap_bits;
    logic       evt_en;
  } ptc_mode_t;

  typedef struct packed {
    logic restart;
    logic capture;
    logic load;
  } ptc_cmd_t;
endpackage

// File: rtl/ptc_regs.sv
`timescale 1ns/1ps
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output ptc_mode_t         mode,
  output ptc_cmd_t          cmd,
  output logic [CNT_W-1:0]  load_val,
  output logic [INC_W-1:0]  norm_inc,
  output logic [INC_W-1:0]  trim_inc,
  output logic [CNT_W-1:0]  trim_period,
  output logic [CNT_W-1:0]  wrap_period,
  output logic              trim_clear
);
  logic              hit_ctrl, hit_time, hit_wper, hit_cper, hit_step;
  logic [CNT_W-1:0]  snap;
  logic [DATA_W-1:0] rd_next;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_time = (bus_addr == ADDR_W'(OFS_TIME));
  assign hit_wper = (bus_addr == ADDR_W'(OFS_WPER));
  assign hit_cper = (bus_addr == ADDR_W'(OFS_CPER));
  assign hit_step = (bus_addr == ADDR_W'(OFS_STEP));

  always_comb begin
    cmd.restart = bus_we && hit_ctrl && bus_wdata[CB_RESTART];
    cmd.capture = bus_we && hit_ctrl && bus_wdata[CB_CAPTURE];
    cmd.load    = bus_we && hit_time;
  end

  assign load_val   = bus_wdata[CNT_W-1:0];
  assign trim_clear = bus_we && hit_cper;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= '0;
      norm_inc    <= '0;
      trim_inc    <= '0;
      trim_period <= '0;
      wrap_period <= '0;
    end else if (bus_we) begin
      if (hit_ctrl) begin
        mode.run       <= bus_wdata[CB_RUN];
        mode.wrap_bits <= bus_wdata[CB_WRAP_HI:CB_WRAP_LO];
        mode.evt_en    <= bus_wdata[CB_EVT];
      end
      if (hit_step) begin
        norm_inc <= bus_wdata[SB_NORM_LSB +: INC_W];
        trim_inc <= bus_wdata[SB_TRIM_LSB +: INC_W];
      end
      if (hit_cper) trim_period <= bus_wdata[CNT_W-1:0];
      if (hit_wper) wrap_period <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              snap <= '0;
    else if (cmd.capture) snap <= cur_cnt;
  end

  always_comb begin
    rd_next = '0;
    if (hit_ctrl) begin
      rd_next[CB_RUN]                 = mode.run;
      rd_next[CB_WRAP_HI:CB_WRAP_LO]  = mode.wrap_bits;
      rd_next[CB_EVT]                 = mode.evt_en;
    end else if (hit_time) begin
      rd_next = DATA_W'(snap);
    end else if (hit_wper) begin
      rd_next = DATA_W'(wrap_period);
    end else if (hit_cper) begin
      rd_next = DATA_W'(trim_period);
    end else if (hit_step) begin
      rd_next[SB_NORM_LSB +: INC_W] = norm_inc;
      rd_next[SB_TRIM_LSB +: INC_W] = trim_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R8
  capture_latch_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.capture |=> snap == $past(cur_cnt));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.capture |=> $stable(snap));
endmodule

// File: rtl/ptc_rate.sv
`timescale 1ns/1ps
module ptc_rate
  import ptc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             clear,
  input  logic [CNT_W-1:0] trim_period,
  input  logic [INC_W-1:0] norm_inc,
  input  logic [INC_W-1:0] trim_inc,
  output logic [INC_W-1:0] step_inc,
  output logic             trim_sel
);
  logic [CNT_W-1:0] tally;
  logic             trim_on;

  assign trim_on  = (trim_period != '0);
  assign trim_sel = trim_on && (tally >= trim_period);
  assign step_inc = trim_sel ? trim_inc : norm_inc;

  always_ff @(posedge clk) begin
    if (rst || clear)              tally <= '0;
    else if (advance) begin
      if (trim_sel || !trim_on)    tally <= '0;
      else                         tally <= tally + 1'b1;
    end
  end

  // R3
  trim_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && trim_sel && !clear) |=> (!trim_sel || trim_period != $past(trim_period)));

  // R3
  trim_off_chk: assert property (@(posedge clk) disable iff (rst)
    (trim_period == '0) |-> (step_inc == norm_inc));
endmodule

// File: rtl/ptc_count.sv
`timescale 1ns/1ps
module ptc_count
  import ptc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ptc_mode_t        mode,
  input  ptc_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  input  logic [INC_W-1:0] step_inc,
  input  logic [CNT_W-1:0] wrap_period,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_pulse,
  output logic             advance
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum, folded;
  logic             wrap_armed, wrap_hit;

  assign sum        = {1'b0, cnt} + SUM_W'(step_inc);
  assign folded     = sum - {1'b0, wrap_period};
  assign wrap_armed = (mode.wrap_bits == 2'b11) && (wrap_period != '0);
  assign wrap_hit   = wrap_armed && (sum >= {1'b0, wrap_period});
  assign advance    = mode.run && !cmd.restart && !cmd.load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= 1'b0;
      if (cmd.restart)   cnt <= '0;
      else if (cmd.load) cnt <= load_val;
      else if (mode.run) begin
        if (wrap_hit) begin
          cnt       <= folded[CNT_W-1:0];
          ovf_pulse <= mode.evt_en;
        end else begin
          cnt       <= sum[CNT_W-1:0];
        end
      end
    end
  end

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.restart |=> cnt == '0);

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && !cmd.restart) |=> cnt == $past(load_val));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode.run && !cmd.restart && !cmd.load) |=> $stable(cnt));

  // R5
  evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> ($past(mode.evt_en) && $past(mode.run)));
endmodule

// File: rtl/ptc_timer.sv
`timescale 1ns/1ps
module ptc_timer
  import ptc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  time_now,
  output logic              wrap_evt
);
  ptc_mode_t        mode;
  ptc_cmd_t         cmd;
  logic [CNT_W-1:0] load_val, trim_period, wrap_period;
  logic [INC_W-1:0] norm_inc, trim_inc, step_inc;
  logic             trim_clear, trim_sel, advance;

  ptc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_cnt(time_now),
    .mode(mode), .cmd(cmd), .load_val(load_val), .norm_inc(norm_inc),
    .trim_inc(trim_inc), .trim_period(trim_period),
    .wrap_period(wrap_period), .trim_clear(trim_clear)
  );

  ptc_rate #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst(rst), .advance(advance), .clear(trim_clear),
    .trim_period(trim_period), .norm_inc(norm_inc), .trim_inc(trim_inc),
    .step_inc(step_inc), .trim_sel(trim_sel)
  );

  ptc_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .mode(mode), .cmd(cmd), .load_val(load_val),
    .step_inc(step_inc), .wrap_period(wrap_period), .cnt(time_now),
    .ovf_pulse(wrap_evt), .advance(advance)
  );

  // R4
  fold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && $stable(wrap_period)) |-> (time_now < wrap_period));

  // R3
  trim_needs_period_chk: assert property (@(posedge clk) disable iff (rst)
    trim_sel |-> (trim_period != '0));
endmodule

// File: tb/ptc_timer_test.sv
`timescale 1ns/1ps
module ptc_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] time_now;
  logic        wrap_evt;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit started = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  ptc_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_now(time_now), .wrap_evt(wrap_evt)
  );

  // behavioural reference state
  bit          m_run, m_evt;
  bit [1:0]    m_wrap;
  int unsigned m_ninc, m_tinc, m_cper, m_wper, m_cyc, m_cap, m_cnt, m_rd;
  bit          m_ovf;

  function automatic int unsigned ref_read(input bit [7:0] a);
    case (a)
      8'h00: return (int'(m_run)) | (int'(m_wrap) << 4) | (int'(m_evt) << 7);
      8'h04: return m_cap;
      8'h0C: return m_wper;
      8'h10: return m_cper;
      8'h14: return m_ninc | (m_tinc << 8);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_evt = 0; m_wrap = 0; m_ninc = 0; m_tinc = 0;
      m_cper = 0; m_wper = 0; m_cyc = 0; m_cap = 0; m_cnt = 0;
      m_rd = 0; m_ovf = 0; started = 1;
    end else begin
      bit restart_c, capture_c, load_c, use_trim, folded;
      int unsigned step;
      longint unsigned nx;
      int unsigned old_cnt;
      m_rd = ref_read(bus_addr);
      restart_c = bus_we && bus_addr == 8'h00 && bus_wdata[9];
      capture_c = bus_we && bus_addr == 8'h00 && bus_wdata[11];
      load_c    = bus_we && bus_addr == 8'h04;
      use_trim  = (m_cper != 0) && (m_cyc >= m_cper);
      step      = use_trim ? m_tinc : m_ninc;
      old_cnt   = m_cnt;
      m_ovf = 0;
      folded = 0;
      if (restart_c) m_cnt = 0;
      else if (load_c) m_cnt = bus_wdata;
      else if (m_run) begin
        nx = longint'(m_cnt) + longint'(step);
        if (m_wrap == 2'b11 && m_wper != 0 && nx >= longint'(m_wper)) begin
          nx = nx - longint'(m_wper);
          folded = 1;
        end
        m_cnt = int'(nx & 64'hFFFF_FFFF);
        m_ovf = folded && m_evt;
      end
      if (bus_we && bus_addr == 8'h10) m_cyc = 0;
      else if (m_run && !restart_c && !load_c)
        m_cyc = (use_trim || m_cper == 0) ? 0 : m_cyc + 1;
      if (capture_c) m_cap = old_cnt;
      if (bus_we) begin
        case (bus_addr)
          8'h00: begin m_run = bus_wdata[0]; m_wrap = bus_wdata[5:4]; m_evt = bus_wdata[7]; end
          8'h0C: m_wper = bus_wdata;
          8'h10: m_cper = bus_wdata;
          8'h14: begin m_ninc = bus_wdata[6:0]; m_tinc = bus_wdata[14:8]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input int unsigned act, input int unsigned exp, input string t, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk(time_now, m_cnt, tag, "time_now");
      chk(32'(wrap_evt), 32'(m_ovf), tag, "wrap_evt");
      chk(bus_rdata, m_rd, tag, "bus_rdata");
    end
  end

  task automatic wr(input bit [7:0] a, input int unsigned d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input bit [7:0] a, output int unsigned v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned v, a, b;
    int evts;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    chk(time_now, 0, "R1", "count after reset");
    chk(32'(wrap_evt), 0, "R1", "wrap after reset");
    chk(bus_rdata, 0, "R1", "rdata after reset");

    tag = "R9";
    wr(8'h14, 32'h0000_0503);
    rd(8'h14, v); chk(v, 32'h0503, "R9", "step readback");

    tag = "R2";
    a = time_now;
    wr(8'h00, 32'h1);
    chk(time_now, a, "R10", "no step on enabling edge");
    idle(1);
    a = time_now; idle(5); b = time_now;
    chk(b - a, 15, "R2", "normal step x5");
    rd(8'h00, v); chk(v, 1, "R9", "ctrl readback");

    tag = "R3";
    wr(8'h10, 3);
    idle(2);
    a = time_now; idle(4); b = time_now;
    chk(b - a, 14, "R3", "one trim per four cycles");
    idle(7);
    a = time_now; idle(4); b = time_now;
    chk(b - a, 14, "R3", "trim cadence later");
    wr(8'h10, 0);
    a = time_now; idle(4); b = time_now;
    chk(b - a, 12, "R3", "trim off");

    tag = "R7";
    wr(8'h04, 90);
    chk(time_now, 90, "R7", "load value");

    tag = "R4";
    wr(8'h0C, 100);
    wr(8'h00, 32'hB1);
    evts = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (wrap_evt) evts++;
      if (time_now >= 100) chk(time_now, 99, "R4", "count below period");
    end
    chk(32'(evts > 0), 1, "R5", "wrap events seen");
    wr(8'h14, 32'h0000_2807);
    wr(8'h10, 2);
    idle(60);

    tag = "R5";
    wr(8'h00, 32'h31);
    evts = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wrap_evt) evts++;
    end
    chk(evts, 0, "R5", "no event with bit7 clear");

    tag = "R4";
    wr(8'h00, 32'h91);
    idle(40);
    chk(32'(time_now > 100), 1, "R4", "no fold with bit5 clear");

    tag = "R4";
    wr(8'h10, 0);
    wr(8'h14, 32'h0000_0005);
    wr(8'h0C, 32'h8000_0000);
    wr(8'h04, 32'h7FFF_FFF0);
    wr(8'h00, 32'hB1);
    idle(5);
    chk(32'(time_now < 32'h8000_0000), 1, "R4", "fold at 2^31");

    tag = "R6";
    wr(8'h00, 32'h2B1);
    chk(time_now, 0, "R6", "restart zero");
    idle(3);

    tag = "R8";
    a = time_now;
    wr(8'h00, 32'h8B1);
    idle(6);
    rd(8'h04, v); chk(v, a, "R8", "captured value");
    idle(4);
    rd(8'h04, v); chk(v, a, "R8", "capture stable");
    rd(8'h00, v); chk(v, 32'hB1, "R8", "command bits read zero");

    tag = "R2";
    wr(8'h00, 32'h0);
    a = time_now; idle(10);
    chk(time_now, a, "R2", "hold when stopped");

    tag = "R9";
    rd(8'h08, v); chk(v, 0, "R9", "unmapped read");
    rd(8'h05, v); chk(v, 0, "R9", "unaligned read");
    rd(8'h0C, v); chk(v, 32'h8000_0000, "R9", "period readback");

    tag = "R7";
    wr(8'h04, 32'h1234);
    chk(time_now, 32'h1234, "R7", "load while stopped");
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule